// File: doc/BRIEF.md
# Dual-Output Signed-Count PWM Timer

The block is one PWM timer that drives a pair of outputs. A 16-bit two's-complement counter starts at a programmable start value and counts upward. A prescaler set by a 3-bit exponent slows the count. When the counter equals the period-end compare, it returns to the start value. A mid-period compare marks the half-cycle point, and the block reports it only as an event.

Each output has its own set compare and its own clear compare. This lets the two outputs carry different duty cycles and different phase offsets. The counter stops when the run input is low. It also stops while a debug or wait halt request is present, unless that request's keep-running enable is set. Each output drives its pin only while its output enable is high; otherwise the pin is low.

Top module: `pwm_pair_gen`

## Requirements
- R1: While `rst_n` is low, and on the first cycles after reset, `cnt` is 0, `match` is 0 and both outputs are low.
- R2: On the first clock edge at which `run` is sampled high after being low, `cnt` loads `init_val`. At the same edge both output states clear to low and `match` goes to 0.
- R3: While counting is active, one count tick occurs every 2^`prsc` clock cycles. The first tick falls on the 2^`prsc`-th edge after the start edge. Each tick adds one to `cnt`.
- R4: On a tick where `cnt` equals `cmp_full`, the counter loads `init_val` instead of incrementing.
- R5: On a tick where `cnt` equals `cmp_a_on`, the A state goes high. On a tick where `cnt` equals `cmp_a_off`, it goes low. If both compares match on the same tick, low wins.
- R6: The B state follows the same rule as R5, using `cmp_b_on` and `cmp_b_off`. It is independent of A.
- R7: A match of `cmp_half` raises `match` bit 0 only. It changes neither output.
- R8: For one cycle after each tick, `match` carries one bit for each compare that equalled `cnt` on that tick. The bit order is 0 half, 1 full, 2 A-on, 3 A-off, 4 B-on, 5 B-off. `match` is 0 in every other cycle.
- R9: While `run` is low, `cnt` and the output states hold their values.
- R10: While `dbg_halt` is high and `dbg_keep` is low, counting pauses. The same holds while `wait_halt` is high and `wait_keep` is low. Counting resumes once the request drops or its keep enable is set.
- R11: `out_a` equals the A state ANDed with `oe_a`, and `out_b` equals the B state ANDed with `oe_b`. Both are combinational and take effect in the same cycle.
- R12: The counter wraps from 32767 to -32768 when incrementing. All compares are equality tests on the 16-bit two's-complement value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Counter run enable; a rising edge restarts the period |
| prsc | input | 3 | Prescaler exponent, divide by 2^prsc |
| dbg_halt | input | 1 | Debug halt request |
| dbg_keep | input | 1 | Keep counting during debug halt |
| wait_halt | input | 1 | Wait halt request |
| wait_keep | input | 1 | Keep counting during wait halt |
| init_val | input | 16 | Start value loaded at start and at period end |
| cmp_half | input | 16 | Half-cycle event compare |
| cmp_full | input | 16 | Period-end compare |
| cmp_a_on | input | 16 | Output A set compare |
| cmp_a_off | input | 16 | Output A clear compare |
| cmp_b_on | input | 16 | Output B set compare |
| cmp_b_off | input | 16 | Output B clear compare |
| oe_a | input | 1 | Output A enable |
| oe_b | input | 1 | Output B enable |
| cnt | output | 16 | Current counter value |
| match | output | 6 | Per-compare match pulses |
| out_a | output | 1 | Gated output A |
| out_b | output | 1 | Gated output B |

## Verification
- **When results appear.** The counter, the match pulses and the output states change on the clock edge that carries a tick. They are therefore visible one edge after the 2^`prsc` cycles that produce that tick. The start load appears one edge after `run` is first sampled high. The enable gating takes effect in the same cycle.
- **How the bench samples.** The bench drives inputs on falling edges. It advances its reference one step per rising edge, using the inputs that edge saw, and compares on the following falling edge. No result is read earlier than the edge that makes it.
- **Arithmetic checks.** Directed checks compute counts directly from tick arithmetic. Examples are the start value plus the number of elapsed ticks, and the value after the 16-bit wrap.

// File: rtl/pwm_pair_gen.sv
module pwm_pair_gen #(
  parameter int W  = 16,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [PW-1:0] prsc,
  input  logic          dbg_halt,
  input  logic          dbg_keep,
  input  logic          wait_halt,
  input  logic          wait_keep,
  input  logic [W-1:0]  init_val,
  input  logic [W-1:0]  cmp_half,
  input  logic [W-1:0]  cmp_full,
  input  logic [W-1:0]  cmp_a_on,
  input  logic [W-1:0]  cmp_a_off,
  input  logic [W-1:0]  cmp_b_on,
  input  logic [W-1:0]  cmp_b_off,
  input  logic          oe_a,
  input  logic          oe_b,
  output logic [W-1:0]  cnt,
  output logic [5:0]    match,
  output logic          out_a,
  output logic          out_b
);
  localparam int PRE_W = (1 << PW) - 1;

  logic             run_q, st_a, st_b;
  logic [PRE_W-1:0] pre, mask;
  logic [5:0]       eq;
  logic             start, active, tick;

  assign start  = run & ~run_q;
  assign active = run & ~(dbg_halt & ~dbg_keep) & ~(wait_halt & ~wait_keep);
  assign mask   = ~({PRE_W{1'b1}} << prsc);
  assign tick   = active & ((pre & mask) == mask);
  assign eq     = {cnt == cmp_b_off, cnt == cmp_b_on, cnt == cmp_a_off,
                   cnt == cmp_a_on, cnt == cmp_full, cnt == cmp_half};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      pre   <= '0;
      cnt   <= '0;
      match <= '0;
      st_a  <= 1'b0;
      st_b  <= 1'b0;
    end else begin
      run_q <= run;
      match <= '0;
      if (start) begin
        pre  <= '0;
        cnt  <= init_val;
        st_a <= 1'b0;
        st_b <= 1'b0;
      end else if (active) begin
        pre <= pre + 1'b1;
        if (tick) begin
          match <= eq;
          cnt   <= eq[1] ? init_val : cnt + 1'b1;
          if (eq[3])      st_a <= 1'b0;
          else if (eq[2]) st_a <= 1'b1;
          if (eq[5])      st_b <= 1'b0;
          else if (eq[4]) st_b <= 1'b1;
        end
      end
    end
  end

  assign out_a = st_a & oe_a;
  assign out_b = st_b & oe_b;

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(cnt) && $stable(st_a) && $stable(st_b)));
  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt == $past(init_val) && !st_a && !st_b && match == '0));
  assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|match) |-> $past(tick));
  assert_offwins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    match[3] |-> !st_a);
  assert_offwins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    match[5] |-> !st_b);
  assert_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && run && dbg_halt && !dbg_keep) |=> $stable(cnt));
endmodule

// File: tb/pwm_pair_gen_tb.sv
module pwm_pair_gen_tb;
  localparam time PERIOD = 10;

  logic clk = 0, rst_n = 0, run = 0;
  logic [2:0] prsc = 0;
  logic dbg_halt = 0, dbg_keep = 0, wait_halt = 0, wait_keep = 0;
  logic [15:0] init_val = 0, cmp_half = 0, cmp_full = 0;
  logic [15:0] cmp_a_on = 0, cmp_a_off = 0, cmp_b_on = 0, cmp_b_off = 0;
  logic oe_a = 1, oe_b = 1;
  logic [15:0] cnt;
  logic [5:0] match;
  logic out_a, out_b;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [15:0] m_cnt;
  logic [6:0]  m_pre;
  logic [5:0]  m_match;
  logic        m_a, m_b, m_runq;

  pwm_pair_gen u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .prsc(prsc),
    .dbg_halt(dbg_halt), .dbg_keep(dbg_keep), .wait_halt(wait_halt), .wait_keep(wait_keep),
    .init_val(init_val), .cmp_half(cmp_half), .cmp_full(cmp_full),
    .cmp_a_on(cmp_a_on), .cmp_a_off(cmp_a_off), .cmp_b_on(cmp_b_on), .cmp_b_off(cmp_b_off),
    .oe_a(oe_a), .oe_b(oe_b), .cnt(cnt), .match(match), .out_a(out_a), .out_b(out_b));

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model();
    logic st, tk;
    logic [6:0] mk;
    logic [5:0] e;
    st = run && !m_runq;
    m_runq = run;
    m_match = 0;
    if (st) begin
      m_cnt = init_val; m_pre = 0; m_a = 0; m_b = 0;
    end else if (run && !(dbg_halt && !dbg_keep) && !(wait_halt && !wait_keep)) begin
      mk = 7'((1 << prsc) - 1);
      tk = (m_pre % (mk + 7'd1)) == mk;
      m_pre = m_pre + 7'd1;
      if (tk) begin
        e[0] = m_cnt == cmp_half;  e[1] = m_cnt == cmp_full;
        e[2] = m_cnt == cmp_a_on;  e[3] = m_cnt == cmp_a_off;
        e[4] = m_cnt == cmp_b_on;  e[5] = m_cnt == cmp_b_off;
        m_match = e;
        m_a = e[3] ? 1'b0 : (e[2] ? 1'b1 : m_a);
        m_b = e[5] ? 1'b0 : (e[4] ? 1'b1 : m_b);
        m_cnt = e[1] ? init_val : m_cnt + 16'd1;
      end
    end
  endtask

  task automatic step();
    @(posedge clk);
    model();
    @(negedge clk);
    chk("R3 R4 counter", cnt, m_cnt);
    chk("R8 match", match, m_match);
    chk("R5 out_a", out_a, m_a & oe_a);
    chk("R6 out_b", out_b, m_b & oe_b);
  endtask

  task automatic cfg(input int c);
    init_val = -16'sd6; cmp_full = 16'sd5;
    case (c)
      0: begin cmp_half = 0; cmp_a_on = -16'sd4; cmp_a_off = 16'sd2; cmp_b_on = 16'sd3; cmp_b_off = -16'sd2; end
      1: begin cmp_half = 0; cmp_a_on = 16'sd1; cmp_a_off = 16'sd1; cmp_b_on = -16'sd6; cmp_b_off = 16'sd5; end
      2: begin cmp_half = 0; cmp_a_on = 16'sd5; cmp_a_off = -16'sd6; cmp_b_on = 16'sd0; cmp_b_off = 16'sd4; end
      default: begin cmp_half = -16'sd1; cmp_a_on = 16'sd20; cmp_a_off = 16'sd30; cmp_b_on = -16'sd20; cmp_b_off = 16'sd100; end
    endcase
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] saved;
    int halfs, hi;
    m_cnt = 0; m_pre = 0; m_match = 0; m_a = 0; m_b = 0; m_runq = 0;
    cfg(0);
    repeat (3) @(negedge clk);
    chk("R1 cnt in reset", cnt, 0);
    chk("R1 match in reset", match, 0);
    rst_n = 1;
    step();
    chk("R1 outputs after reset", {out_a, out_b}, 0);
    chk("R1 cnt after reset", cnt, 0);

    run = 1; step();
    chk("R2 start loads init", cnt, 16'hFFFA);
    chk("R2 outputs low at start", {out_a, out_b}, 0);

    run = 0; step();
    prsc = 2; run = 1; step();
    repeat (12) step();
    chk("R3 three ticks at divide by 4", cnt, 16'hFFFD);

    run = 0; step(); saved = cnt;
    repeat (10) step();
    chk("R9 counter held while stopped", cnt, saved);

    prsc = 0; run = 1; step(); step();
    dbg_halt = 1; step(); saved = cnt;
    repeat (8) step();
    chk("R10 debug halt freezes", cnt, saved);
    dbg_keep = 1; repeat (4) step();
    chk("R10 debug keep resumes", cnt != saved, 1);
    dbg_halt = 0; dbg_keep = 0;
    wait_halt = 1; step(); saved = cnt;
    repeat (8) step();
    chk("R10 wait halt freezes", cnt, saved);
    wait_halt = 0; repeat (4) step();
    chk("R10 wait release resumes", cnt != saved, 1);

    run = 0; step();
    init_val = 16'h7FFD; cmp_full = 16'h8003;
    run = 1; step();
    repeat (5) step();
    chk("R12 wrap past 32767", cnt, 16'h8002);

    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 4; c++) begin
        run = 0; step();
        cfg(c); prsc = 3'(p); run = 1; step();
        repeat (36 << p) step();
      end
    end

    run = 0; step(); cfg(3); prsc = 0; run = 1; step();
    halfs = 0; hi = 0;
    repeat (12) begin
      step();
      if (match == 6'b000001) halfs++;
      if (out_a || out_b) hi++;
    end
    chk("R7 one half-cycle pulse per period", halfs, 1);
    chk("R7 half match drives no output", hi, 0);

    run = 0; step(); cfg(0); run = 1; step();
    repeat (4) step();
    chk("R11 A state high", out_a, 1);
    oe_a = 0; #1;
    chk("R11 disabled A held low", out_a, 0);
    oe_b = 0; #1;
    chk("R11 disabled B held low", out_b, 0);
    oe_a = 1; #1;
    chk("R11 re-enabled A follows state", out_a, m_a);
    oe_b = 1; step();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule